// File: doc/BRIEF.md
# Serial Read-Response Checker

This block sits behind a line receiver that has already recovered bit timing. After a read command leaves the chip, the block is armed with the command's target ID and byte address. It then watches a stream of sampled bits qualified by a valid strobe. It waits for a start bit and captures a 2-bit response tag, a 32-bit read word and a 4-bit check code. It runs a 4-bit CRC over the frame, and it reports the read word right-aligned together with a status byte and error flags.

The block also drives the address-compression record kept by the command encoder. A clean response issues an update pulse carrying the ID-qualified, word-aligned address. Any failure issues an invalidate pulse instead: a bad check code, a non-zero tag, a missing response, or a new command arriving while one is still open. A programmable wait limit bounds the time spent waiting for the start bit.

Top module: `rsp_frame_check`

## Requirements
- R1: After a synchronous active-low reset, status is 0x00, `done`, `la_update` and `la_inval` are low, and `rd_data`, `rx_tag`, `rx_crc`, `crc_err`, `tag_err` and `la_addr` are all zero.
- R2: A `start` accepted while no command is open makes status 0x01 after that clock edge. In the same edge it clears `rd_data`, `rx_tag`, `rx_crc`, `crc_err` and `tag_err`, and it loads `la_addr` with `{cmd_id, cmd_addr[20:2], 2'b00}`.
- R3: The check code uses polynomial x^4+x^2+x+1 with an initial value of zero, fed MSB first. It is fed the start bit (a 1), then the 32 data bits, then the 4 received code bits; the tag bits are not fed. `crc_err` is high exactly when the final register value is non-zero.
- R4: After the start bit, the frame bits arrive in this order: 2 tag bits, then 32 data bits, then 4 code bits, each field MSB first. The first data bit lands in `rd_data[31]`, and the received code is shown on `rx_crc`.
- R5: `rx_tag` shows the received tag, first bit in bit 1. `tag_err` is high when the tag is non-zero.
- R6: The clock edge that samples the final code bit sets status to 0x02 and raises `done` for exactly one cycle. All result outputs then hold until the next `start`.
- R7: A completed frame with a good code and a zero tag raises `la_update` for one cycle, together with `done`.
- R8: `la_inval` pulses together with `done` for every other outcome: a code error, a tag error, a timeout or an abort. `la_update` and `la_inval` are never high together.
- R9: The wait limit L (`tmo_limit`, at least 1) counts the cycles after the `start` edge. If no start bit is sampled in cycles 1 to L, the edge of cycle L ends the command with status 0x83. A start bit sampled in cycle L is still accepted.
- R10: A cycle with `bit_valid` low is ignored whatever `bit_in` holds. While waiting, valid 0 bits are ignored and only a valid 1 counts as the start bit.
- R11: A `start` while a command is open abandons it: status becomes 0x80, `done` and `la_inval` pulse, and the new command is not taken.
- R12: Valid bits that arrive while no command is open are ignored: no `done` pulse, and status and results do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Read command issued; arms the checker |
| cmd_id | input | 2 | Target ID of the issued command |
| cmd_addr | input | 21 | Byte address of the issued command |
| tmo_limit | input | 16 | Cycles allowed to wait for the start bit |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Sampled response line bit |
| done | output | 1 | One-cycle pulse when a command ends |
| status | output | 8 | 0x00 stopped, 0x01 busy, 0x02 complete, 0x80 abort, 0x83 timeout |
| rd_data | output | 32 | Received read word, right-aligned |
| rx_tag | output | 2 | Received response tag |
| rx_crc | output | 4 | Received check code |
| crc_err | output | 1 | Check-code failure |
| tag_err | output | 1 | Non-zero tag |
| la_update | output | 1 | Pulse: refresh the encoder's last-address record |
| la_inval | output | 1 | Pulse: invalidate the encoder's last-address record |
| la_addr | output | 23 | ID-qualified word address of the open command |

## Verification
The status change to 0x01 is due one edge after `start` is sampled. A frame result, with its `done`, `la_update` or `la_inval` pulse, is due at the edge that samples the last code bit. A timeout result is due exactly L edges after the `start` edge. The bench drives inputs on falling edges and reads every result at the falling edge that follows the edge where it is due. At that point it checks the outputs, and one cycle later it confirms that the pulse has dropped while the results hold. The timeout case is also checked one cycle early, where no result may yet appear.

// File: rtl/rsp_chk_pkg.sv
// Shared types for the read-response checker.
// Assumes: the status byte values are fixed by the command/response agreement.
package rsp_chk_pkg;

    typedef enum logic [7:0] {
        ST_STOPPED  = 8'h00,
        ST_SENDING  = 8'h01,
        ST_COMPLETE = 8'h02,
        ST_BAD_CMD  = 8'h80,
        ST_TIMEOUT  = 8'h83
    } rsp_status_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RECV = 2'd2
    } rsp_phase_e;

endpackage

// File: rtl/rsp_crc_engine.sv
// Bit-serial CRC register, MSB first, initial value zero.
// Assumes: `init` and `feed` are never high in the same cycle. `init` both
// clears the register and absorbs the bit presented in that cycle.
module rsp_crc_engine #(
    parameter int          CRC_W = 4,
    parameter logic [CRC_W-1:0] POLY  = 4'h7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             feed,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_nxt
);

    function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
    endfunction

    // Next value when the current bit is absorbed into the running register.
    always_comb crc_nxt = step(crc_q, bit_in);

    // Register update: restart from zero, or absorb one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= '0;
        else if (init)
            crc_q <= step('0, bit_in);
        else if (feed)
            crc_q <= crc_nxt;
    end

endmodule

// File: rtl/rsp_shift_capture.sv
// Capture shift register for the frame body that follows the start bit.
// Holds FRAME_W-1 bits; the final bit is supplied alongside by the caller.
// Assumes: `clear` takes priority over `shift`.
module rsp_shift_capture #(
    parameter int FRAME_W = 38,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic               bit_in,
    output logic [FRAME_W-2:0] frame_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               last
);

    // Final body bit is being taken in this cycle.
    always_comb last = shift && (cnt_q == CNT_W'(FRAME_W - 1));

    // Shift bits in at the bottom and count them.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            frame_q <= '0;
            cnt_q   <= '0;
        end else if (shift) begin
            frame_q <= {frame_q[FRAME_W-3:0], bit_in};
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rsp_wait_timer.sv
// Counts wait cycles and flags the cycle in which the limit is reached.
// Assumes: limit >= 1; `clear` takes priority over `run`.
module rsp_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);

    logic [TMO_W-1:0] cnt_q;

    // Expiry: this is wait cycle number `limit` and it is still empty.
    always_comb expire = run && (cnt_q == limit - TMO_W'(1));

    // Cycle counter for the wait phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + TMO_W'(1);
    end

endmodule

// File: rtl/rsp_frame_check.sv
// Read-response checker: waits for a start bit, captures tag, data and code,
// checks the code, and reports status plus last-address record updates.
// Assumes: bits arrive already timing-recovered, one per bit_valid cycle.
module rsp_frame_check
    import rsp_chk_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int ID_W   = 2,
    parameter int TAG_W  = 2,
    parameter int DATA_W = 32,
    parameter int CRC_W  = 4,
    parameter int TMO_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ID_W-1:0]        cmd_id,
    input  logic [ADDR_W-1:0]      cmd_addr,
    input  logic [TMO_W-1:0]       tmo_limit,
    input  logic                   bit_valid,
    input  logic                   bit_in,
    output logic                   done,
    output logic [7:0]             status,
    output logic [DATA_W-1:0]      rd_data,
    output logic [TAG_W-1:0]       rx_tag,
    output logic [CRC_W-1:0]       rx_crc,
    output logic                   crc_err,
    output logic                   tag_err,
    output logic                   la_update,
    output logic                   la_inval,
    output logic [ID_W+ADDR_W-1:0] la_addr
);

    localparam int FRAME_W = TAG_W + DATA_W + CRC_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    rsp_phase_e  phase_q;
    rsp_status_e status_q;

    logic               start_bit;
    logic               body_bit;
    logic               crc_init, crc_feed;
    logic [CRC_W-1:0]   crc_q, crc_nxt;
    logic [FRAME_W-2:0] frame_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               last;
    logic               expire;
    logic [FRAME_W-1:0] full_frame;
    logic [ID_W+ADDR_W-1:0] rec_addr;

    // Qualified line events for this cycle.
    always_comb begin
        start_bit = bit_valid && bit_in && (phase_q == PH_WAIT) && !start;
        body_bit  = bit_valid && (phase_q == PH_RECV) && !start;
        crc_init  = start_bit;
        crc_feed  = body_bit && (cnt_q >= CNT_W'(TAG_W));
    end

    // Whole frame including the bit sampled in this cycle.
    always_comb full_frame = {frame_q, bit_in};

    // Record value for the encoder: ID on top, word-aligned address below.
    always_comb rec_addr = {cmd_id, cmd_addr & ~ADDR_W'(3)};

    rsp_crc_engine #(.CRC_W(CRC_W), .POLY(CRC_W'(7))) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_init),
        .feed    (crc_feed),
        .bit_in  (bit_in),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    rsp_shift_capture #(.FRAME_W(FRAME_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .shift   (body_bit),
        .bit_in  (bit_in),
        .frame_q (frame_q),
        .cnt_q   (cnt_q),
        .last    (last)
    );

    rsp_wait_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .run    ((phase_q == PH_WAIT) && !start && !start_bit),
        .limit  (tmo_limit),
        .expire (expire)
    );

    // Command sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            status_q  <= ST_STOPPED;
            done      <= 1'b0;
            rd_data   <= '0;
            rx_tag    <= '0;
            rx_crc    <= '0;
            crc_err   <= 1'b0;
            tag_err   <= 1'b0;
            la_update <= 1'b0;
            la_inval  <= 1'b0;
            la_addr   <= '0;
        end else begin
            done      <= 1'b0;
            la_update <= 1'b0;
            la_inval  <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q  <= PH_WAIT;
                        status_q <= ST_SENDING;
                        rd_data  <= '0;
                        rx_tag   <= '0;
                        rx_crc   <= '0;
                        crc_err  <= 1'b0;
                        tag_err  <= 1'b0;
                        la_addr  <= rec_addr;
                    end
                end
                PH_WAIT: begin
                    if (start) begin
                        phase_q  <= PH_IDLE;
                        status_q <= ST_BAD_CMD;
                        done     <= 1'b1;
                        la_inval <= 1'b1;
                    end else if (start_bit) begin
                        phase_q <= PH_RECV;
                    end else if (expire) begin
                        phase_q  <= PH_IDLE;
                        status_q <= ST_TIMEOUT;
                        done     <= 1'b1;
                        la_inval <= 1'b1;
                    end
                end
                PH_RECV: begin
                    if (start) begin
                        phase_q  <= PH_IDLE;
                        status_q <= ST_BAD_CMD;
                        done     <= 1'b1;
                        la_inval <= 1'b1;
                    end else if (last) begin
                        phase_q   <= PH_IDLE;
                        status_q  <= ST_COMPLETE;
                        done      <= 1'b1;
                        rx_tag    <= full_frame[FRAME_W-1 -: TAG_W];
                        rd_data   <= full_frame[CRC_W +: DATA_W];
                        rx_crc    <= full_frame[CRC_W-1:0];
                        crc_err   <= (crc_nxt != '0);
                        tag_err   <= (full_frame[FRAME_W-1 -: TAG_W] != '0);
                        la_update <= (crc_nxt == '0) && (full_frame[FRAME_W-1 -: TAG_W] == '0);
                        la_inval  <= (crc_nxt != '0) || (full_frame[FRAME_W-1 -: TAG_W] != '0);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb status = status_q;

endmodule

// File: rtl/rsp_frame_check_sva.sv
// Temporal checks on the read-response checker, bound to every instance.
// Assumes: the bound instance uses its default widths.
module rsp_frame_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        done,
    input logic [7:0]  status,
    input logic [31:0] rd_data,
    input logic        crc_err,
    input logic        tag_err,
    input logic        la_update,
    input logic        la_inval
);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && status != 8'h01) |=> (status == 8'h01));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && status != 8'h01 && !done) |=> ($stable(rd_data) && $stable(status) && !done));

    assert_update_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        la_update |-> (done && status == 8'h02 && !crc_err && !tag_err));

    assert_record_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(la_update && la_inval));

    assert_fail_invalidates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status != 8'h02 || crc_err || tag_err)) |-> la_inval);

    assert_timeout_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h83 && $changed(status)) |-> done);

endmodule

bind rsp_frame_check rsp_frame_check_sva u_sva (.*);

// File: tb/rsp_frame_check_test.sv
module rsp_frame_check_test;

    typedef struct packed {
        logic [1:0]  id;
        logic [20:0] addr;
        logic [1:0]  tag;
        logic [31:0] data;
        logic [3:0]  cx;
        logic        gap;
        logic [1:0]  lead;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 21'h000000, 2'b00, 32'hDEADBEEF, 4'h0, 1'b0, 2'd0},
        '{2'd1, 21'h1FFFFF, 2'b00, 32'h00000000, 4'h0, 1'b1, 2'd2},
        '{2'd2, 21'h001234, 2'b00, 32'hFFFFFFFF, 4'h1, 1'b0, 2'd1},
        '{2'd3, 21'h0A5A5A, 2'b01, 32'h80000001, 4'h0, 1'b1, 2'd0},
        '{2'd0, 21'h100003, 2'b10, 32'h12345678, 4'h8, 1'b0, 2'd0},
        '{2'd1, 21'h000004, 2'b00, 32'h00000001, 4'h0, 1'b0, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd_id = '0;
    logic [20:0] cmd_addr = '0;
    logic [15:0] tmo_limit = 16'd200;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        done;
    logic [7:0]  status;
    logic [31:0] rd_data;
    logic [1:0]  rx_tag;
    logic [3:0]  rx_crc;
    logic        crc_err, tag_err, la_update, la_inval;
    logic [22:0] la_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rsp_frame_check uut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Spec CRC step: x^4+x^2+x+1, MSB first.
    function automatic logic [3:0] cstep(input logic [3:0] c, input logic b);
        logic fb;
        fb = c[3] ^ b;
        return {c[2:0], 1'b0} ^ ({4{fb}} & 4'h7);
    endfunction

    function automatic logic [3:0] code_of(input logic [31:0] d);
        logic [3:0] c;
        c = cstep(4'h0, 1'b1);
        for (int i = 31; i >= 0; i--) c = cstep(c, d[i]);
        return c;
    endfunction

    task automatic send_bit(input logic b, input logic gap);
        if (gap) begin
            bit_valid = 1'b0; bit_in = 1'b1;
            @(negedge clk);
        end
        bit_valid = 1'b1; bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0; bit_in = 1'b0;
    endtask

    task automatic pulse_start(input logic [1:0] id, input logic [20:0] a);
        cmd_id = id; cmd_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_body(input logic [1:0] tag, input logic [31:0] d, input logic [3:0] c, input logic gap);
        for (int i = 1; i >= 0; i--) send_bit(tag[i], gap);
        for (int i = 31; i >= 0; i--) send_bit(d[i], gap);
        for (int i = 3; i >= 0; i--) send_bit(c[i], gap);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R6 watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status", status, 8'h00);
        check("R1 done", done, 0);
        check("R1 data", rd_data, 0);
        check("R1 pulses", {la_update, la_inval}, 0);
        check("R1 la_addr", la_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: bits while idle are ignored
        for (int i = 0; i < 45; i++) begin
            bit_valid = 1'b1; bit_in = i[0];
            @(negedge clk);
            if (done) check("R12 no done while idle", done, 0);
        end
        bit_valid = 1'b0;
        check("R12 status idle", status, 8'h00);
        check("R12 data idle", rd_data, 0);

        // Vector table walk: R2..R8, R10
        for (int v = 0; v < NV; v++) begin
            logic [3:0]  code;
            logic        exp_ce, exp_te;
            logic [31:0] held;
            code   = code_of(VECS[v].data) ^ VECS[v].cx;
            exp_ce = (VECS[v].cx != 0);
            exp_te = (VECS[v].tag != 0);
            pulse_start(VECS[v].id, VECS[v].addr);
            check("R2 status busy", status, 8'h01);
            check("R2 cleared data", rd_data, 0);
            check("R2 la_addr", la_addr, {VECS[v].id, VECS[v].addr[20:2], 2'b00});
            for (int z = 0; z < VECS[v].lead; z++) send_bit(1'b0, VECS[v].gap);
            check("R10 zeros ignored", {done, status}, {1'b0, 8'h01});
            send_bit(1'b1, VECS[v].gap);
            send_body(VECS[v].tag, VECS[v].data, code, VECS[v].gap);
            check("R6 done", done, 1);
            check("R6 status complete", status, 8'h02);
            check("R4 data", rd_data, VECS[v].data);
            check("R4 rx_crc", rx_crc, code);
            check("R5 tag", rx_tag, VECS[v].tag);
            check("R5 tag_err", tag_err, exp_te);
            check("R3 crc_err", crc_err, exp_ce);
            check("R7 la_update", la_update, !exp_ce && !exp_te);
            check("R8 la_inval", la_inval, exp_ce || exp_te);
            held = rd_data;
            @(negedge clk);
            check("R6 done pulse drops", {done, la_update, la_inval}, 0);
            check("R6 data held", rd_data, held);
            check("R6 status held", status, 8'h02);
        end

        // R9: timeout exactly L cycles after start edge
        tmo_limit = 16'd5;
        pulse_start(2'd1, 21'h000100);
        repeat (4) @(negedge clk);
        check("R9 not yet timed out", {done, status}, {1'b0, 8'h01});
        @(negedge clk);
        check("R9 timeout done", done, 1);
        check("R9 timeout status", status, 8'h83);
        check("R8 timeout invalidates", {la_update, la_inval}, 2'b01);

        // R9: start bit in the last allowed cycle is accepted
        pulse_start(2'd0, 21'h000008);
        repeat (4) @(negedge clk);
        send_bit(1'b1, 1'b0);
        check("R9 late start bit accepted", {done, status}, {1'b0, 8'h01});
        send_body(2'b00, 32'hCAFEF00D, code_of(32'hCAFEF00D), 1'b0);
        check("R9 late frame complete", status, 8'h02);
        check("R9 late frame data", rd_data, 32'hCAFEF00D);
        tmo_limit = 16'd200;

        // R11: start while a frame is being received
        pulse_start(2'd2, 21'h000040);
        send_bit(1'b1, 1'b0);
        for (int i = 0; i < 10; i++) send_bit(i[0], 1'b0);
        pulse_start(2'd3, 21'h000080);
        check("R11 abort status", status, 8'h80);
        check("R11 abort pulses", {done, la_update, la_inval}, 3'b101);
        check("R11 new command not taken", la_addr, {2'd2, 19'h10, 2'b00});
        @(negedge clk);
        check("R11 stays idle", {done, status}, {1'b0, 8'h80});

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule